// File: doc/BRIEF.md
# Channel Command Sequencer

This block is the command register for one serial channel. The host writes a byte of command bits. Any mix of those bits is allowed. The block latches the byte, works out which channel actions were asked for, and runs them one after another in a fixed order. Each action is a one-cycle request toward the channel logic. The block then waits for that logic to acknowledge before it starts the next action.

The actions are:
- clearing the FIFOs, the channel status and the DMA status;
- reinitialising the protocol state;
- turning the transmitter and the receiver on and off;
- a global reset.

The register keeps the written value while work is pending and returns to zero once the last action has been retired. A zero read therefore tells the host the command is complete. The transmit-enable and receive-enable levels are held inside the block and change only when the commands that own them complete.

A write that arrives while the register is nonzero is dropped and sets a sticky error flag. An action that is never acknowledged is abandoned after a programmable number of cycles, and a second sticky flag records the abandonment. Both flags are read through a second read address.

Top module: `chan_cmd_seq`

## Requirements
- R1: After reset the command register reads 0x00, the status byte reads 0x00, both enable levels are low and no request output is high.
- R2: A write while the command register is zero is accepted. With rd_sel=0, rd_data returns the written byte in the cycle after the write. Bit meanings are: bit 7 reserved (must be 0), bit 6 clear channel, bit 5 initialise, bit 4 reset all, bit 3 transmitter on, bit 2 transmitter off, bit 1 receiver on, bit 0 receiver off. With rd_sel=1, rd_data bit 0 is the write-while-busy flag, bit 1 is the timeout flag, and the other bits are zero.
- R3: The requested actions run in this order: clear, initialise, receiver on, receiver off, transmitter on, transmitter off. Each runs exactly once, and actions that were not requested are skipped.
- R4: When bit 4 is set and bit 7 is clear, only the global reset request is issued, whatever else the byte holds. On completion it drives both enables low and clears both sticky flags.
- R5: Each action raises its request for exactly one cycle. At most one request is high at a time, and the next request is not raised before the current one is acknowledged or abandoned.
- R6: The command register returns to zero one cycle after the last action is retired, and stays nonzero until then.
- R7: The clear action raises the FIFO-clear, status-clear and DMA-status-clear requests together. On completion it drives both enables low.
- R8: tx_en and rx_en are held levels. They change only on an acknowledged on, off, clear or reset action. When on and off for the same direction are written together, the off action runs later and decides the level.
- R9: A write while the command register is nonzero leaves the register and the pending work unchanged and sets the write-while-busy flag. The flag stays set until a reset-all action completes.
- R10: A write with bit 7 set issues no request, leaves the enables unchanged, and the register reads zero again two cycles after the write.
- R11: An action that is not acknowledged within TIMEOUT_CYC cycles is abandoned. Abandoning it sets the timeout flag, leaves the enables unchanged, and lets the remaining actions continue.
- R12: The initialise action raises only the protocol-reinitialise request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe for the command register |
| wr_data | input | 8 | Host write data |
| rd_sel | input | 1 | Read select: 0 command register, 1 status byte |
| rd_data | output | 8 | Host read data |
| chan_ack | input | 1 | Channel acknowledge for the current request |
| req_fifo_clr | output | 1 | Request to empty both FIFOs |
| req_stat_clr | output | 1 | Request to clear current transmit and receive status |
| req_dma_clr | output | 1 | Request to clear the DMA status |
| req_init | output | 1 | Request to reinitialise protocol state |
| req_rst_all | output | 1 | Request for a global channel reset |
| req_rx_on | output | 1 | Request to turn the receiver on |
| req_rx_off | output | 1 | Request to turn the receiver off |
| req_tx_on | output | 1 | Request to turn the transmitter on |
| req_tx_off | output | 1 | Request to turn the transmitter off |
| tx_en | output | 1 | Held transmitter enable level |
| rx_en | output | 1 | Held receiver enable level |

## Verification
The hardest situation to reach from the ports is a host write that lands while an earlier command is still pending. Acknowledged actions retire within a few cycles, so there is little time to hit. The bench makes that window long by withholding the acknowledge, which holds each action for the full timeout. It then writes a command that would visibly change an enable level, checks that the level and the register did not move, and checks that both sticky flags are set. Every command byte with bit 7 clear is also swept at several acknowledge latencies. The order of the observed requests is compared against a sequence the bench builds from the byte.

// File: rtl/chan_cmd_pkg.sv
// Shared definitions for the channel command sequencer.
// Assumes an 8-bit command byte whose bit positions are fixed by the
// host software, and a processing order that equals the step index order.
package chan_cmd_pkg;

    localparam int CMD_W     = 8;
    localparam int NUM_STEPS = 7;
    localparam int STEP_W    = $clog2(NUM_STEPS);

    // Command byte bit positions (host visible, fixed)
    localparam int BIT_RSVD  = 7;
    localparam int BIT_CLR   = 6;
    localparam int BIT_INIT  = 5;
    localparam int BIT_RST   = 4;
    localparam int BIT_TXON  = 3;
    localparam int BIT_TXOFF = 2;
    localparam int BIT_RXON  = 1;
    localparam int BIT_RXOFF = 0;

    // Step index equals processing rank: lower index runs first
    typedef enum logic [STEP_W-1:0] {
        ST_CLR   = 3'd0,
        ST_INIT  = 3'd1,
        ST_RXON  = 3'd2,
        ST_RXOFF = 3'd3,
        ST_TXON  = 3'd4,
        ST_TXOFF = 3'd5,
        ST_RST   = 3'd6
    } step_e;

    typedef logic [NUM_STEPS-1:0] step_mask_t;

    // Turn a written byte into the set of steps it requests
    function automatic step_mask_t decode_cmd(input logic [CMD_W-1:0] c);
        step_mask_t m;
        m = '0;
        if (c[BIT_RSVD]) begin
            m = '0;
        end else if (c[BIT_RST]) begin
            m[int'(ST_RST)] = 1'b1;
        end else begin
            m[int'(ST_CLR)]   = c[BIT_CLR];
            m[int'(ST_INIT)]  = c[BIT_INIT];
            m[int'(ST_RXON)]  = c[BIT_RXON];
            m[int'(ST_RXOFF)] = c[BIT_RXOFF];
            m[int'(ST_TXON)]  = c[BIT_TXON];
            m[int'(ST_TXOFF)] = c[BIT_TXOFF];
        end
        return m;
    endfunction

endpackage

// File: rtl/cmd_host_port.sv
// Host side of the command register: holds the written byte, accepts a
// write only when the register reads zero, self-clears once the sequencer
// has gone idle, keeps the two sticky error flags and muxes the read data.
// Assumes seq_idle is high only when no step is pending or in flight.
module cmd_host_port
    import chan_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CMD_W-1:0] wr_data,
    input  logic             rd_sel,
    input  logic             seq_idle,
    input  logic             tmo_set,
    input  logic             flags_clr,
    output logic [CMD_W-1:0] rd_data,
    output logic [CMD_W-1:0] cmd_q,
    output logic             accept,
    output logic             busy_err,
    output logic             tmo_err
);

    localparam int STAT_BUSY = 0;
    localparam int STAT_TMO  = 1;

    logic reg_zero;

    // Write is taken only when no earlier command is outstanding
    always_comb begin
        reg_zero = (cmd_q == '0);
        accept   = wr_en && reg_zero;
    end

    // Command register: load on accept, return to zero when work is done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (accept) begin
            cmd_q <= wr_data;
        end else if (!reg_zero && seq_idle) begin
            cmd_q <= '0;
        end
    end

    // Sticky flag for writes dropped while busy; setting beats clearing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_err <= 1'b0;
        end else if (wr_en && !reg_zero) begin
            busy_err <= 1'b1;
        end else if (flags_clr) begin
            busy_err <= 1'b0;
        end
    end

    // Sticky flag for abandoned steps; setting beats clearing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmo_err <= 1'b0;
        end else if (tmo_set) begin
            tmo_err <= 1'b1;
        end else if (flags_clr) begin
            tmo_err <= 1'b0;
        end
    end

    // Read mux between the command register and the status byte
    always_comb begin
        rd_data = '0;
        if (rd_sel) begin
            rd_data[STAT_BUSY] = busy_err;
            rd_data[STAT_TMO]  = tmo_err;
        end else begin
            rd_data = cmd_q;
        end
    end

endmodule

// File: rtl/cmd_step_queue.sv
// Pending-step set and fixed-priority picker. A load replaces the set with
// the decoded command; a retire removes the step just finished.
// Assumes load and retire are never high in the same cycle.
module cmd_step_queue
    import chan_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CMD_W-1:0] load_cmd,
    input  logic             retire,
    input  step_e            retire_step,
    output logic             pending_any,
    output step_e            next_step
);

    step_mask_t pending;

    // Pending set: loaded from a new command, trimmed as steps finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
        end else if (load) begin
            pending <= decode_cmd(load_cmd);
        end else if (retire) begin
            pending[retire_step] <= 1'b0;
        end
    end

    // Lowest pending index is the next step in processing order
    always_comb begin
        logic found;
        found     = 1'b0;
        next_step = ST_CLR;
        for (int i = 0; i < NUM_STEPS; i++) begin
            if (pending[i] && !found) begin
                next_step = step_e'(i);
                found     = 1'b1;
            end
        end
        pending_any = |pending;
    end

endmodule

// File: rtl/cmd_step_engine.sv
// Issues one step at a time: a one-cycle request, then a wait for the
// channel acknowledge, bounded by a timeout counter. The acknowledge is
// accepted in any cycle of the wait, including the request cycle.
// Assumes TIMEOUT_CYC is at least 1.
module cmd_step_engine
    import chan_cmd_pkg::*;
#(
    parameter int TIMEOUT_CYC = 1024
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pending_any,
    input  step_e                next_step,
    input  logic                 chan_ack,
    output logic [NUM_STEPS-1:0] req_vec,
    output step_e                cur_step,
    output logic                 engine_idle,
    output logic                 step_done,
    output logic                 step_tmo
);

    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

    typedef enum logic {ENG_IDLE, ENG_WAIT} eng_state_e;

    eng_state_e       state;
    logic             req_q;
    logic [CNT_W-1:0] wait_cnt;

    // Completion and abandonment of the step in flight
    always_comb begin
        engine_idle = (state == ENG_IDLE);
        step_done   = (state == ENG_WAIT) && chan_ack;
        step_tmo    = (state == ENG_WAIT) && !chan_ack && (wait_cnt == CNT_LAST);
    end

    // Step state machine with request pulse and wait counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ENG_IDLE;
            req_q    <= 1'b0;
            cur_step <= ST_CLR;
            wait_cnt <= '0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    req_q <= 1'b0;
                    if (pending_any) begin
                        cur_step <= next_step;
                        req_q    <= 1'b1;
                        wait_cnt <= '0;
                        state    <= ENG_WAIT;
                    end
                end
                default: begin
                    req_q <= 1'b0;
                    if (step_done || step_tmo) begin
                        state <= ENG_IDLE;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // One request line per step, high only in the issue cycle
    for (genvar g = 0; g < NUM_STEPS; g++) begin : g_req
        assign req_vec[g] = req_q && (int'(cur_step) == g);
    end

endmodule

// File: rtl/cmd_enable_hold.sv
// Held transmitter and receiver enable levels. They move only when a step
// that owns them is acknowledged; abandoned steps leave them alone.
// Assumes step_done is a single-cycle strobe qualified by cur_step.
module cmd_enable_hold
    import chan_cmd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  step_done,
    input  step_e cur_step,
    output logic  tx_en,
    output logic  rx_en
);

    // Update the levels on acknowledged enable, disable, clear or reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en <= 1'b0;
            rx_en <= 1'b0;
        end else if (step_done) begin
            case (cur_step)
                ST_CLR, ST_RST: begin
                    tx_en <= 1'b0;
                    rx_en <= 1'b0;
                end
                ST_RXON:  rx_en <= 1'b1;
                ST_RXOFF: rx_en <= 1'b0;
                ST_TXON:  tx_en <= 1'b1;
                ST_TXOFF: tx_en <= 1'b0;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/chan_cmd_seq.sv
// Top of the channel command sequencer: host register, pending-step set,
// step engine and held enables. Request outputs are decoded from the
// engine's one-hot request vector; the clear step fans out to three lines.
// Assumes chan_ack is synchronous to clk.
module chan_cmd_seq
    import chan_cmd_pkg::*;
#(
    parameter int TIMEOUT_CYC = 1024
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CMD_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [CMD_W-1:0] rd_data,
    input  logic             chan_ack,
    output logic             req_fifo_clr,
    output logic             req_stat_clr,
    output logic             req_dma_clr,
    output logic             req_init,
    output logic             req_rst_all,
    output logic             req_rx_on,
    output logic             req_rx_off,
    output logic             req_tx_on,
    output logic             req_tx_off,
    output logic             tx_en,
    output logic             rx_en
);

    logic [CMD_W-1:0]     cmd_q;
    logic                 accept;
    logic                 busy_err;
    logic                 tmo_err;
    logic                 pending_any;
    step_e                next_step;
    step_e                cur_step;
    logic [NUM_STEPS-1:0] req_vec;
    logic                 engine_idle;
    logic                 step_done;
    logic                 step_tmo;
    logic                 seq_idle;
    logic                 flags_clr;

    // Sequencer idle and reset-all flag clearing
    always_comb begin
        seq_idle  = engine_idle && !pending_any;
        flags_clr = step_done && (cur_step == ST_RST);
    end

    cmd_host_port u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_sel    (rd_sel),
        .seq_idle  (seq_idle),
        .tmo_set   (step_tmo),
        .flags_clr (flags_clr),
        .rd_data   (rd_data),
        .cmd_q     (cmd_q),
        .accept    (accept),
        .busy_err  (busy_err),
        .tmo_err   (tmo_err)
    );

    cmd_step_queue u_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (accept),
        .load_cmd    (wr_data),
        .retire      (step_done || step_tmo),
        .retire_step (cur_step),
        .pending_any (pending_any),
        .next_step   (next_step)
    );

    cmd_step_engine #(
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .pending_any (pending_any),
        .next_step   (next_step),
        .chan_ack    (chan_ack),
        .req_vec     (req_vec),
        .cur_step    (cur_step),
        .engine_idle (engine_idle),
        .step_done   (step_done),
        .step_tmo    (step_tmo)
    );

    cmd_enable_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_done (step_done),
        .cur_step  (cur_step),
        .tx_en     (tx_en),
        .rx_en     (rx_en)
    );

    // Map the request vector onto the channel-facing lines
    always_comb begin
        req_fifo_clr = req_vec[int'(ST_CLR)];
        req_stat_clr = req_vec[int'(ST_CLR)];
        req_dma_clr  = req_vec[int'(ST_CLR)];
        req_init     = req_vec[int'(ST_INIT)];
        req_rst_all  = req_vec[int'(ST_RST)];
        req_rx_on    = req_vec[int'(ST_RXON)];
        req_rx_off   = req_vec[int'(ST_RXOFF)];
        req_tx_on    = req_vec[int'(ST_TXON)];
        req_tx_off   = req_vec[int'(ST_TXOFF)];
    end

endmodule

// File: rtl/chan_cmd_seq_chk.sv
// Property checker for the channel command sequencer, bound to the top.
// Assumes it sees the top's internal command register, request vector and
// write-while-busy flag through the bind connections below.
module chan_cmd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [3:0] wr_hi,
    input logic [7:0] cmd_q,
    input logic [6:0] req_vec,
    input logic       chan_ack,
    input logic       tx_en,
    input logic       rx_en,
    input logic       busy_err
);

    AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_vec));                                                  // R5

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_vec) |=> !(|req_vec));                                         // R5

    AST_BUSY_WRITE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cmd_q != 8'h00) |=> (cmd_q == $past(cmd_q) || cmd_q == 8'h00)); // R9

    AST_BUSY_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cmd_q != 8'h00) |=> busy_err);                             // R9

    AST_RESERVED_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hi[3] && cmd_q == 8'h00) |=> ##1 (cmd_q == 8'h00 && !(|req_vec))); // R10

    AST_RST_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hi == 4'b0001 && cmd_q == 8'h00) |=> ##1 (req_vec == 7'b1000000)); // R4

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en != $past(tx_en)) |-> $past(chan_ack));                        // R8

    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en != $past(rx_en)) |-> $past(chan_ack));                        // R8

endmodule

bind chan_cmd_seq chan_cmd_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_hi    (wr_data[7:4]),
    .cmd_q    (cmd_q),
    .req_vec  (req_vec),
    .chan_ack (chan_ack),
    .tx_en    (tx_en),
    .rx_en    (rx_en),
    .busy_err (busy_err)
);

// File: tb/chan_cmd_seq_bench.sv
// Self-checking bench for chan_cmd_seq: sweeps every command byte with
// bit 7 clear at several acknowledge latencies, then drives the timeout,
// busy-write, reserved and reset-all cases.
module chan_cmd_seq_bench;

    localparam int TMO = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic       chan_ack = 1'b0;
    logic req_fifo_clr, req_stat_clr, req_dma_clr, req_init, req_rst_all;
    logic req_rx_on, req_rx_off, req_tx_on, req_tx_off;
    logic tx_en, rx_en;

    int checks = 0;
    int errors = 0;

    // channel model state
    int          lat = 0;
    bit          ack_off = 1'b0;
    bit          armed = 1'b0;
    int          armed_cnt = 0;
    int          rec_n = 0;
    logic [31:0] rec_seq = '0;
    int          overlap_err = 0;
    int          trio_err = 0;

    // expected state
    bit exp_tx = 1'b0;
    bit exp_rx = 1'b0;

    always #4 clk = ~clk;

    chan_cmd_seq #(.TIMEOUT_CYC(TMO)) u_chan_cmd_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .chan_ack(chan_ack),
        .req_fifo_clr(req_fifo_clr), .req_stat_clr(req_stat_clr),
        .req_dma_clr(req_dma_clr), .req_init(req_init),
        .req_rst_all(req_rst_all), .req_rx_on(req_rx_on),
        .req_rx_off(req_rx_off), .req_tx_on(req_tx_on),
        .req_tx_off(req_tx_off), .tx_en(tx_en), .rx_en(rx_en)
    );

    // Channel model: records each request and acknowledges after lat cycles
    always @(negedge clk) begin
        int code;
        code = -1;
        if (req_fifo_clr)     code = 0;
        else if (req_init)    code = 1;
        else if (req_rx_on)   code = 2;
        else if (req_rx_off)  code = 3;
        else if (req_tx_on)   code = 4;
        else if (req_tx_off)  code = 5;
        else if (req_rst_all) code = 6;
        if (req_fifo_clr != req_stat_clr || req_fifo_clr != req_dma_clr) trio_err++;
        if (chan_ack) chan_ack = 1'b0;
        if (code >= 0) begin
            if (armed) overlap_err++;
            rec_seq = {rec_seq[27:0], 4'(code)};
            rec_n++;
            if (!ack_off) begin
                if (lat == 0) chan_ack = 1'b1;
                else begin armed = 1'b1; armed_cnt = lat; end
            end
        end else if (armed) begin
            armed_cnt--;
            if (armed_cnt == 0) begin chan_ack = 1'b1; armed = 1'b0; end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic do_write(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n;
        rd_sel = 1'b0;
        n = 0;
        while (rd_data != 8'h00 && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk(rd_data == 8'h00, req, {24'h0, rd_data}, 32'h0);
        repeat (2) @(negedge clk);
    endtask

    // Build the expected request sequence and update the expected levels
    task automatic expect_cmd(input logic [7:0] v, output logic [31:0] s, output int n);
        s = '0;
        n = 0;
        if (v[7]) begin
            n = 0;
        end else if (v[4]) begin
            s = 32'h6; n = 1; exp_tx = 1'b0; exp_rx = 1'b0;
        end else begin
            if (v[6]) begin s = {s[27:0], 4'h0}; n++; exp_tx = 1'b0; exp_rx = 1'b0; end
            if (v[5]) begin s = {s[27:0], 4'h1}; n++; end
            if (v[1]) begin s = {s[27:0], 4'h2}; n++; exp_rx = 1'b1; end
            if (v[0]) begin s = {s[27:0], 4'h3}; n++; exp_rx = 1'b0; end
            if (v[3]) begin s = {s[27:0], 4'h4}; n++; exp_tx = 1'b1; end
            if (v[2]) begin s = {s[27:0], 4'h5}; n++; exp_tx = 1'b0; end
        end
    endtask

    task automatic run_cmd(input logic [7:0] v, input string req_ord);
        logic [31:0] es;
        int en;
        rec_n = 0;
        rec_seq = '0;
        expect_cmd(v, es, en);
        do_write(v);
        chk(rd_data == v, "R2", {24'h0, rd_data}, {24'h0, v});
        wait_idle("R6");
        chk(rec_n == en && rec_seq == es, req_ord, rec_seq, es);
        chk(tx_en == exp_tx, v[6] ? "R7" : "R8", {31'h0, tx_en}, {31'h0, exp_tx});
        chk(rx_en == exp_rx, v[6] ? "R7" : "R8", {31'h0, rx_en}, {31'h0, exp_rx});
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_sel = 1'b0;
        chk(rd_data == 8'h00, "R1", {24'h0, rd_data}, 32'h0);
        rd_sel = 1'b1;
        @(negedge clk);
        chk(rd_data == 8'h00, "R1", {24'h0, rd_data}, 32'h0);
        rd_sel = 1'b0;
        chk({tx_en, rx_en} == 2'b00, "R1", {30'h0, tx_en, rx_en}, 32'h0);
        chk(!(req_fifo_clr | req_init | req_rst_all | req_rx_on | req_rx_off | req_tx_on | req_tx_off),
            "R1", 32'h1, 32'h0);

        // R3 R4 R6 R7 R8 sweep of all bytes with bit 7 clear
        for (int v = 0; v < 128; v++) begin
            lat = v % 3;
            run_cmd(8'(v), (v & 16) != 0 ? "R4" : "R3");
        end
        chk(overlap_err == 0, "R5", overlap_err, 0);
        chk(trio_err == 0, "R7", trio_err, 0);
        rd_sel = 1'b1;
        @(negedge clk);
        chk(rd_data == 8'h00, "R9", {24'h0, rd_data}, 32'h0);
        rd_sel = 1'b0;

        // R12 initialise alone
        lat = 1;
        run_cmd(8'h20, "R12");

        // R8 on and off written together: off wins
        run_cmd(8'h0F, "R8");
        chk({tx_en, rx_en} == 2'b00, "R8", {30'h0, tx_en, rx_en}, 32'h0);

        // R11 and R9: tx on, rx off, then withhold ack and write while busy
        run_cmd(8'h09, "R3");
        ack_off = 1'b1;
        rec_n = 0;
        rec_seq = '0;
        do_write(8'h04);
        do_write(8'h02);
        chk(rd_data == 8'h04, "R9", {24'h0, rd_data}, 32'h04);
        wait_idle("R11");
        chk(rec_n == 1 && rec_seq == 32'h5, "R11", rec_seq, 32'h5);
        chk(tx_en == 1'b1, "R11", {31'h0, tx_en}, 32'h1);
        chk(rx_en == 1'b0, "R9", {31'h0, rx_en}, 32'h0);
        rd_sel = 1'b1;
        @(negedge clk);
        chk(rd_data == 8'h03, "R9", {24'h0, rd_data}, 32'h03);
        rd_sel = 1'b0;
        ack_off = 1'b0;

        // R10 reserved byte: readback then zero, no request, levels kept
        rec_n = 0;
        do_write(8'h8B);
        chk(rd_data == 8'h8B, "R10", {24'h0, rd_data}, 32'h8B);
        @(negedge clk);
        chk(rd_data == 8'h00, "R10", {24'h0, rd_data}, 32'h0);
        repeat (4) @(negedge clk);
        chk(rec_n == 0, "R10", rec_n, 0);
        chk(tx_en == 1'b1, "R10", {31'h0, tx_en}, 32'h1);

        // R4 reset all clears both flags and levels
        exp_tx = 1'b1;
        exp_rx = 1'b0;
        run_cmd(8'h7F, "R4");
        rd_sel = 1'b1;
        @(negedge clk);
        chk(rd_data == 8'h00, "R4", {24'h0, rd_data}, 32'h0);
        rd_sel = 1'b0;

        finish_run();
    end

endmodule